// File: doc/BRIEF.md
# Serial DAC Write Master

This block drives a three-wire serial link to a 16-bit voltage-output converter from a parallel command port. A command carries a 16-bit output code and a 2-bit power-down selection. The block accepts it through a valid/ready handshake and turns it into one 24-bit write frame. The frame consists of an active-low frame strobe, a serial clock that idles low, and a data line that changes only on serial clock rises. The receiver samples the data line on each serial clock fall.

All timing is counted in system clock cycles. The parameters set the serial clock phase length, the lead time from the strobe fall to the first clock rise, the hold time after the last fall, and the minimum strobe-high gap between frames. A park input lets the strobe rest low between frames. In that case a fresh command first raises the strobe for the gap time, and then the frame starts. An abort input cuts a frame short during its lead or shift phase, which deliberately leaves the receiver with a write it must discard.

Top module: `dac_frame_tx`

## Requirements
- R1: A frame carries 24 bits, most significant first. The bits are six zeros, then `cmd_mode[1]`, `cmd_mode[0]`, then `cmd_code[15]` down to `cmd_code[0]`. Each bit is sampled on a falling `sclk` while `sync_n` is low.
- R2: `sdo` changes only in a cycle where `sclk` was low in the previous cycle. It is therefore stable through every high phase and across every falling edge.
- R3: Within a frame, every `sclk` high phase and every low phase between two bits lasts exactly `DIV_CYC` cycles. A completed frame has exactly 24 falling edges.
- R4: `sclk` is low whenever `sync_n` is high. `sync_n` is low for at least `SETUP_CYC` cycles before the first rise of a frame.
- R5: After the 24th falling edge, `sync_n` stays low for `HOLD_CYC` cycles and then rises. `done` pulses for one cycle in the same cycle that `sync_n` rises after a completed frame.
- R6: `sync_n` is high for at least `GAP_CYC` consecutive cycles before any fall.
- R7: `cmd_ready` drops in the cycle after acceptance. After any rise of `sync_n`, `cmd_ready` stays low for `GAP_CYC` cycles. It is high again once the post-frame gap has elapsed.
- R8: While `park_low` is 1 and no command is pending, `sync_n` rests low. A command then raises `sync_n` for `GAP_CYC` cycles before the frame starts. Clearing `park_low` while idle raises `sync_n`.
- R9: `abort` during the lead or shift phase raises `sync_n` and forces `sclk` low on the next cycle. No `done` follows and fewer than 24 falling edges are seen. This holds even when the abort lands on the cycle of the 24th fall.
- R10: During and just after reset, `sync_n`=1, `sclk`=0, `sdo`=0, `done`=0 and `cmd_ready`=1.
- R11: `abort` has no effect while idle, whether `sync_n` rests high or parked low. During the hold phase it ends the hold at once, and the frame still counts as completed with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| park_low | input | 1 | Rest `sync_n` low between frames |
| abort | input | 1 | Cut the current frame short |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_code | input | 16 | Converter output code |
| cmd_mode | input | 2 | Power-down selection, 0 = normal |
| sync_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, launched on rising `sclk` |
| done | output | 1 | One-cycle pulse per completed frame |

## Verification
The abort can meet a frame's own sequencing in the same cycle. It can coincide with the 24th falling edge, or with the single cycle of the hold phase that would otherwise raise the strobe and pulse `done`. The bench derives both cycle offsets from the timing parameters and places the abort exactly on them. The first case must produce an interrupted frame with 23 received bits and no `done`. The second must deliver all 24 bits with `done` raised together with the strobe.

// File: rtl/dac_frame_tx.sv
module dac_frame_tx #(
  parameter int DIV_CYC   = 4,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int GAP_CYC   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        park_low,
  input  logic        abort,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [15:0] cmd_code,
  input  logic [1:0]  cmd_mode,
  output logic        sync_n,
  output logic        sclk,
  output logic        sdo,
  output logic        done
);
  localparam int WORD_W = 24;
  localparam int CNT_W  = $clog2(DIV_CYC + SETUP_CYC + HOLD_CYC + GAP_CYC + 1);
  localparam logic [CNT_W-1:0] DIV_LD   = CNT_W'(DIV_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SETUP, S_SHIFT, S_HOLD} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [4:0]        bits;
  logic [WORD_W-1:0] sh;
  logic              pend;
  logic [WORD_W-1:0] word;
  logic              cut;

  assign word      = {6'b0, cmd_mode, cmd_code};
  assign cmd_ready = (st == S_IDLE);
  assign cut       = abort && (st == S_SETUP || st == S_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bits <= '0; sh <= '0; pend <= 1'b0;
      sync_n <= 1'b1; sclk <= 1'b0; sdo <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cut) begin
        st <= S_GAP; cnt <= GAP_LD; pend <= 1'b0; sync_n <= 1'b1; sclk <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (cmd_valid) begin
              sh <= word; bits <= '0;
              if (sync_n) begin
                st <= S_SETUP; sync_n <= 1'b0; sdo <= word[WORD_W-1]; cnt <= SETUP_LD;
              end else begin
                st <= S_GAP; pend <= 1'b1; sync_n <= 1'b1; cnt <= GAP_LD;
              end
            end else if (park_low && sync_n) begin
              sync_n <= 1'b0;
            end else if (!park_low && !sync_n) begin
              st <= S_GAP; pend <= 1'b0; sync_n <= 1'b1; cnt <= GAP_LD;
            end
          end
          S_GAP: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (pend) begin
              st <= S_SETUP; pend <= 1'b0; sync_n <= 1'b0; sdo <= sh[WORD_W-1]; cnt <= SETUP_LD;
            end else st <= S_IDLE;
          end
          S_SETUP: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else st <= S_SHIFT;
          end
          S_SHIFT: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (!sclk) begin
              sclk <= 1'b1; sdo <= sh[WORD_W-1]; sh <= sh << 1; cnt <= DIV_LD;
            end else begin
              sclk <= 1'b0;
              if (bits == 5'(WORD_W - 1)) begin
                st <= S_HOLD; cnt <= HOLD_LD;
              end else begin
                bits <= bits + 1'b1; cnt <= DIV_LD;
              end
            end
          end
          S_HOLD: begin
            if (cnt == '0 || abort) begin
              st <= S_GAP; cnt <= GAP_LD; pend <= 1'b0;
              sync_n <= 1'b1; done <= 1'b1; sdo <= 1'b0;
            end else cnt <= cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk #(
  parameter int GAP_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic abort,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic sync_n,
  input logic sclk,
  input logic sdo,
  input logic done
);
  localparam int HW = $clog2(GAP_CYC + 1) + 1;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= HW'(GAP_CYC);
    else if (!sync_n) hi_q <= '0;
    else if (hi_q < HW'(GAP_CYC)) hi_q <= hi_q + 1'b1;
  end

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sclk);
  p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sclk) |-> $stable(sdo));
  p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(sync_n));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !sync_n && !cmd_ready |=> sync_n && !sclk);
  p_sync_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> hi_q >= HW'(GAP_CYC));
endmodule

bind dac_frame_tx dac_frame_tx_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .sync_n(sync_n), .sclk(sclk), .sdo(sdo), .done(done)
);

// File: tb/test_dac_frame_tx.sv
module test_dac_frame_tx;
  localparam int DIV = 4, SETUP = 2, HOLD = 1, GAP = 3;
  localparam int FALL24 = SETUP + 1 + DIV * 47;

  logic clk = 1'b0, rst_n = 1'b0, park_low = 1'b0, abort = 1'b0, cmd_valid = 1'b0;
  logic [15:0] cmd_code = '0;
  logic [1:0]  cmd_mode = '0;
  logic cmd_ready, sync_n, sclk, sdo, done;

  dac_frame_tx #(.DIV_CYC(DIV), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .GAP_CYC(GAP)) i_dac_frame_tx (
    .clk(clk), .rst_n(rst_n), .park_low(park_low), .abort(abort), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_mode(cmd_mode),
    .sync_n(sync_n), .sclk(sclk), .sdo(sdo), .done(done));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [23:0] exp_q[$];
  bit abort_pending = 0;
  int delivered = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference monitor, sampled at the falling system clock edge
  logic p_sync = 1'b1, p_sclk = 1'b0, rise_sdo = 1'b0;
  int hi_len = 0, lo_len = 0, sl_len = 0, sh_len = GAP, nbits = 0, gap_left = 0, after_done = 0;
  logic [23:0] rx = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (gap_left > 0) begin
        chk(!cmd_ready, "R7 ready low in gap", cmd_ready, 0);
        gap_left--;
      end else if (after_done == 1) begin
        chk(cmd_ready, "R7 ready back", cmd_ready, 1);
        after_done = 0;
      end
      if (sync_n && sclk) chk(0, "R4 sclk high while idle", sclk, 0);
      if (done && !(sync_n && !p_sync)) chk(0, "R5 done without release", done, 0);
      if (!p_sync && sync_n) begin
        gap_left = GAP - 1;
        if (done) begin
          chk(nbits == 24, "R3 falls per frame", nbits, 24);
          chk(lo_len == HOLD, "R5 hold length", lo_len, HOLD);
          if (exp_q.size() > 0) begin
            chk(rx == exp_q[0], "R1 frame word", rx, exp_q[0]);
            void'(exp_q.pop_front());
          end else chk(0, "R1 unexpected frame", rx, 0);
          delivered++;
          after_done = 1;
        end else if (abort_pending) begin
          chk(nbits < 24, "R9 interrupted bits", nbits, 23);
          if (exp_q.size() > 0) void'(exp_q.pop_front());
          abort_pending = 0;
          after_done = 1;
        end
      end
      if (p_sync && !sync_n) begin
        chk(sh_len >= GAP, "R6 strobe high gap", sh_len, GAP);
        nbits = 0; sl_len = 0;
      end
      if (!sync_n && !p_sclk && sclk) begin
        if (nbits == 0) chk(sl_len >= SETUP, "R4 lead time", sl_len, SETUP);
        else chk(lo_len == DIV, "R3 low phase", lo_len, DIV);
        rise_sdo = sdo;
      end
      if (!sync_n && p_sclk && !sclk) begin
        chk(hi_len == DIV, "R3 high phase", hi_len, DIV);
        chk(sdo == rise_sdo, "R2 sdo stable high", sdo, rise_sdo);
        rx = {rx[22:0], sdo};
        nbits++;
      end
      hi_len = sclk ? (p_sclk ? hi_len + 1 : 1) : 0;
      lo_len = (!sclk && p_sclk) ? 1 : (!sclk ? lo_len + 1 : 0);
      sh_len = sync_n ? sh_len + 1 : 0;
      if (!sync_n) sl_len++;
      p_sync = sync_n; p_sclk = sclk;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [15:0] code, input logic [1:0] mode);
    tick(1);
    cmd_valid = 1'b1; cmd_code = code; cmd_mode = mode;
    while (!cmd_ready) tick(1);
    exp_q.push_back({6'b0, mode, code});
    tick(1);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R7 ready drop", cmd_ready, 0);
  endtask

  task automatic wait_idle();
    while (!(cmd_ready && exp_q.size() == 0 && gap_left == 0)) tick(1);
    tick(2);
  endtask

  task automatic abort_at(input int n, input bit interrupt);
    if (n > 0) tick(n);
    abort_pending = interrupt;
    abort = 1'b1;
    tick(1);
    abort = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    #1 chk(sync_n && !sclk && !sdo && !done && cmd_ready, "R10 reset state",
           {sync_n, sclk, sdo, done, cmd_ready}, 5'b10001);
    rst_n = 1'b1;
    tick(GAP + 2);
    chk(sync_n && cmd_ready, "R10 after reset", {sync_n, cmd_ready}, 2'b11);

    send(16'hABCD, 2'd0);
    send(16'h0000, 2'd3);
    send(16'hFFFF, 2'd1);
    send(16'h8001, 2'd2);
    wait_idle();
    chk(delivered == 4, "R1 frames delivered", delivered, 4);

    abort = 1'b1; tick(3); abort = 1'b0;
    chk(sync_n && cmd_ready && !sclk, "R11 idle abort", {sync_n, cmd_ready}, 2'b11);

    send(16'h1234, 2'd0); abort_at(40, 1);
    chk(sync_n && !sclk && !done, "R9 released", {sync_n, sclk, done}, 3'b100);
    wait_idle();
    send(16'h5555, 2'd2); abort_at(0, 1);
    wait_idle();
    send(16'h3C3C, 2'd1); abort_at(FALL24 - 1, 1);
    wait_idle();
    send(16'hC3A5, 2'd3); abort_at(FALL24 + HOLD - 1, 0);
    wait_idle();
    chk(delivered == 5, "R11 hold abort completes", delivered, 5);
    send(16'h0F0F, 2'd0);
    wait_idle();
    chk(delivered == 6, "R9 recovery frame", delivered, 6);

    park_low = 1'b1;
    tick(4);
    chk(!sync_n && cmd_ready, "R8 parked idle", {sync_n, cmd_ready}, 2'b01);
    abort = 1'b1; tick(2); abort = 1'b0;
    chk(!sync_n && cmd_ready, "R11 parked abort", {sync_n, cmd_ready}, 2'b01);
    send(16'h2468, 2'd1);
    send(16'h7FFF, 2'd0);
    wait_idle();
    tick(3);
    chk(!sync_n && delivered == 8, "R8 parked frames", {sync_n, 8'(delivered)}, 8);
    park_low = 1'b0;
    tick(GAP + 3);
    chk(sync_n && cmd_ready, "R8 unpark", {sync_n, cmd_ready}, 2'b11);
    send(16'h9ABC, 2'd2);
    wait_idle();
    chk(delivered == 9 && exp_q.size() == 0, "R1 final count", delivered, 9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule